// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Core

This block is the per-processor interrupt state machine. It keeps three vector-wide bit sets: pending requests, vectors in service, and the trigger mode of each vector. It also keeps a task-priority register and a spurious/enable configuration register. Requests come in through a set port that carries a vector number and a trigger mode. The processor takes the best eligible request with an acknowledge strobe and retires the active handler with an end-of-interrupt strobe.

Priority is judged by class: a class is a group of 16 vectors, given by the vector number shifted right by 4. A processor-priority value is formed from the task priority and the class of the highest vector in service. A request is offered only when its class beats that value. When a request exists but is held back, an acknowledge gets the configured spurious vector and the request stays pending. Retiring a level-triggered vector announces it on a broadcast strobe, unless directed retirement has been configured.

Top module: `irq_accept_core`

## Requirements
- R1: Among pending requests, the highest-numbered vector is chosen. An acknowledge that finds it deliverable clears that vector's request bit, sets its in-service bit and returns the vector with response kind 1.
- R2: `ppr` equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service class shifted left by 4. An empty in-service set counts as class 0.
- R3: `irq_pending` is high exactly when the block is enabled, a request exists, and either `ppr` is zero or the class of the highest request is strictly greater than the class of `ppr`.
- R4: An acknowledge while a request exists but is not deliverable returns response kind 2 with the spurious vector (bits 7:0 of the configuration register). The request set is left unchanged.
- R5: Each set of a request bit writes that vector's trigger bit: 1 when `set_level` is high, 0 when it is low. A later edge set overwrites an earlier level set.
- R6: An end-of-interrupt clears the highest in-service bit. If that vector's trigger bit is 1 and configuration bit 12 is 0, `eoi_bcast` pulses with that vector.
- R7: While configuration bit 12 is 1, an end-of-interrupt still clears the in-service bit but never pulses `eoi_bcast`.
- R8: While configuration bit 8 (enable) is 0, `irq_pending` stays low and every acknowledge returns response kind 0. Pending requests are kept.
- R9: A configuration write (`wr_sel`=1) stores data bits 8:0 and bit 12. All other bits read back as 0. The register resets to 0x0FF.
- R10: A task-priority write (`wr_sel`=0) stores data bits 7:0. The task priority resets to 0.
- R11: An end-of-interrupt with an empty in-service set changes no state and produces no broadcast.
- R12: `resp_valid` pulses in the cycle after each acknowledge, and only then. `eoi_bcast` appears in the cycle after its end-of-interrupt. Response kinds are 0 for none, 1 for a vector and 2 for spurious.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_valid | input | 1 | Raise the request bit of `set_vector` |
| set_vector | input | VEC_W (8) | Vector to request |
| set_level | input | 1 | Trigger mode of the request: 1 level, 0 edge |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 task priority, 1 configuration |
| wr_data | input | 32 | Write data |
| irq_pending | output | 1 | A deliverable request exists |
| resp_valid | output | 1 | Acknowledge response valid |
| resp_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| resp_vector | output | VEC_W (8) | Returned vector |
| ppr | output | VEC_W (8) | Processor-priority value |
| eoi_bcast | output | 1 | Level vector retired, broadcast |
| eoi_bcast_vector | output | VEC_W (8) | Vector being broadcast |
| task_prio | output | VEC_W (8) | Task-priority register |
| spur_cfg | output | 13 | Configuration register (bits 12 and 8:0 used) |

## Verification
The assertions check several relations on every cycle. `ppr` never falls below the task priority. A pending line implies the enable bit is set. Each acknowledge gets exactly one response, and that response matches the pending line and enable state of the acknowledge cycle. Each broadcast follows an end-of-interrupt taken while directed retirement was off. The bench scenarios show what a single cycle cannot: the exact vector chosen, in-service nesting across several acknowledges, and a request that stays pending through a spurious acknowledge. They also show trigger-bit overwrites and the full sweep of task-priority class against request class.

// File: rtl/irq_core_pkg.sv
// Package: shared encodings for the interrupt acceptance core.
// Assumes the configuration register keeps the enable at bit 8 and
// directed retirement at bit 12.
package irq_core_pkg;
    localparam int CFG_W       = 13;
    localparam int CFG_EN_BIT  = 8;
    localparam int CFG_DIR_BIT = 12;
    localparam logic [CFG_W-1:0] CFG_RESET = 13'h00FF;

    typedef enum logic [1:0] {
        RESP_NONE     = 2'd0,
        RESP_VECTOR   = 2'd1,
        RESP_SPURIOUS = 2'd2
    } resp_kind_e;
endpackage

// File: rtl/vec_prio_enc.sv
// Highest-set-bit finder over an N-bit set.
// Assumes N is a power of two; reports found=0 for an empty set.
module vec_prio_enc #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] top
);
    // Scan upward so the highest set bit is the last one recorded.
    always_comb begin
        found = 1'b0;
        top   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                top   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vector_state.sv
// Request, in-service and trigger bit sets, one bit per vector.
// Assumes at most one set, one acknowledge and one retirement per cycle.
// Within a cycle a new set wins over an acknowledge clear of the same bit,
// and an acknowledge set wins over a retirement clear.
module vector_state #(
    parameter int NUM_VEC = 256,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [VEC_W-1:0]   set_vector,
    input  logic               set_level,
    input  logic               ack_take,
    input  logic [VEC_W-1:0]   ack_vector,
    input  logic               eoi_take,
    input  logic [VEC_W-1:0]   eoi_vector,
    output logic [NUM_VEC-1:0] irr,
    output logic [NUM_VEC-1:0] isr,
    output logic [NUM_VEC-1:0] tmr
);
    logic [NUM_VEC-1:0] set_oh, ack_oh, eoi_oh;
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

    // One-hot decode of the three per-cycle events.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_dec
        assign set_oh[g] = set_valid && (set_vector == VEC_W'(g));
        assign ack_oh[g] = ack_take  && (ack_vector == VEC_W'(g));
        assign eoi_oh[g] = eoi_take  && (eoi_vector == VEC_W'(g));
    end

    // Next state for all three sets.
    always_comb begin
        irr_d = (irr & ~ack_oh) | set_oh;
        isr_d = (isr & ~eoi_oh) | ack_oh;
        tmr_d = (tmr & ~set_oh) | (set_level ? set_oh : '0);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_d;
            isr <= isr_d;
            tmr <= tmr_d;
        end
    end
endmodule

// File: rtl/prio_arbiter.sv
// Forms the processor-priority value and decides deliverability by class.
// Assumes VEC_W >= 5 so that a class is the vector's bits above bit 3.
module prio_arbiter #(
    parameter int VEC_W = 8,
    localparam int CLS_W = VEC_W - 4
) (
    input  logic             enabled,
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] ppr,
    output logic             deliverable,
    output logic             blocked
);
    logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;

    // Processor priority: task priority or in-service class, whichever ranks higher.
    always_comb begin
        isr_cls = isr_found ? isr_top[VEC_W-1:4] : '0;
        tpr_cls = tpr[VEC_W-1:4];
        ppr     = (tpr_cls >= isr_cls) ? tpr : {isr_cls, 4'h0};
        ppr_cls = ppr[VEC_W-1:4];
    end

    // Deliverable when the top request's class strictly beats the priority.
    always_comb begin
        irr_cls     = irr_top[VEC_W-1:4];
        deliverable = enabled && irr_found && ((ppr == '0) || (irr_cls > ppr_cls));
        blocked     = enabled && irr_found && !deliverable;
    end
endmodule

// File: rtl/irq_accept_core.sv
// Top of the per-processor interrupt acceptance core.
// Assumes NUM_VEC is a power of two from 32 to 256, so that a vector fits in
// the low byte of the configuration register. Acknowledge responses and
// broadcasts are registered and appear one cycle after their strobe.
module irq_accept_core
    import irq_core_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vector,
    input  logic             set_level,
    input  logic             ack,
    input  logic             eoi,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    output logic             irq_pending,
    output logic             resp_valid,
    output logic [1:0]       resp_kind,
    output logic [VEC_W-1:0] resp_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_bcast,
    output logic [VEC_W-1:0] eoi_bcast_vector,
    output logic [VEC_W-1:0] task_prio,
    output logic [CFG_W-1:0] spur_cfg
);
    logic [NUM_VEC-1:0] irr, isr, tmr;
    logic               irr_found, isr_found;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic               deliverable, blocked;
    logic               ack_take, eoi_take;
    logic [VEC_W-1:0]   tpr_q;
    logic [CFG_W-1:0]   cfg_q;
    resp_kind_e         kind_q;
    logic               resp_valid_q, bcast_q;
    logic [VEC_W-1:0]   resp_vec_q, bcast_vec_q;

    vector_state #(.NUM_VEC(NUM_VEC)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (set_valid),
        .set_vector (set_vector),
        .set_level  (set_level),
        .ack_take   (ack_take),
        .ack_vector (irr_top),
        .eoi_take   (eoi_take),
        .eoi_vector (isr_top),
        .irr        (irr),
        .isr        (isr),
        .tmr        (tmr)
    );

    vec_prio_enc #(.N(NUM_VEC)) u_irr_enc (.bits(irr), .found(irr_found), .top(irr_top));
    vec_prio_enc #(.N(NUM_VEC)) u_isr_enc (.bits(isr), .found(isr_found), .top(isr_top));

    prio_arbiter #(.VEC_W(VEC_W)) u_arb (
        .enabled     (cfg_q[CFG_EN_BIT]),
        .tpr         (tpr_q),
        .isr_found   (isr_found),
        .isr_top     (isr_top),
        .irr_found   (irr_found),
        .irr_top     (irr_top),
        .ppr         (ppr),
        .deliverable (deliverable),
        .blocked     (blocked)
    );

    // Event qualification for acknowledge and retirement.
    always_comb begin
        ack_take = ack && deliverable;
        eoi_take = eoi && isr_found;
    end

    // Task-priority and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            if (wr_sel) cfg_q <= {wr_data[CFG_DIR_BIT], 3'b000, wr_data[CFG_EN_BIT:0]};
            else        tpr_q <= wr_data[VEC_W-1:0];
        end
    end

    // Acknowledge response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            kind_q       <= RESP_NONE;
            resp_vec_q   <= '0;
        end else begin
            resp_valid_q <= ack;
            if (ack) begin
                if (ack_take) begin
                    kind_q     <= RESP_VECTOR;
                    resp_vec_q <= irr_top;
                end else if (blocked) begin
                    kind_q     <= RESP_SPURIOUS;
                    resp_vec_q <= cfg_q[VEC_W-1:0];
                end else begin
                    kind_q     <= RESP_NONE;
                    resp_vec_q <= '0;
                end
            end
        end
    end

    // Retirement broadcast register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcast_q     <= 1'b0;
            bcast_vec_q <= '0;
        end else begin
            bcast_q <= eoi_take && tmr[isr_top] && !cfg_q[CFG_DIR_BIT];
            if (eoi_take) bcast_vec_q <= isr_top;
        end
    end

    assign irq_pending      = deliverable;
    assign resp_valid       = resp_valid_q;
    assign resp_kind        = kind_q;
    assign resp_vector      = resp_vec_q;
    assign eoi_bcast        = bcast_q;
    assign eoi_bcast_vector = bcast_vec_q;
    assign task_prio        = tpr_q;
    assign spur_cfg         = cfg_q;
endmodule

// Checker: cycle relations between the acceptance core's ports.
// Assumes the reset is synchronous and active low.
module irq_accept_core_chk #(
    parameter int NUM_VEC = 256,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             eoi,
    input logic             irq_pending,
    input logic             resp_valid,
    input logic [1:0]       resp_kind,
    input logic [VEC_W-1:0] ppr,
    input logic             eoi_bcast,
    input logic [VEC_W-1:0] task_prio,
    input logic [12:0]      spur_cfg
);
    // R2
    ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= task_prio);
    // R8
    pend_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> spur_cfg[8]);
    // R12
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> resp_valid);
    // R12
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !resp_valid);
    // R8
    disabled_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !spur_cfg[8]) |=> (resp_kind == 2'd0));
    // R1
    deliver_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending) |=> (resp_kind == 2'd1));
    // R4
    held_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pending) |=> (resp_kind != 2'd1));
    // R6
    bcast_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi));
    // R7
    bcast_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> !$past(spur_cfg[12]));
endmodule

bind irq_accept_core irq_accept_core_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .eoi         (eoi),
    .irq_pending (irq_pending),
    .resp_valid  (resp_valid),
    .resp_kind   (resp_kind),
    .ppr         (ppr),
    .eoi_bcast   (eoi_bcast),
    .task_prio   (task_prio),
    .spur_cfg    (spur_cfg)
);

// File: tb/irq_accept_core_test.sv
`timescale 1ns/1ps
module irq_accept_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 0, set_level = 0, ack = 0, eoi = 0, wr_en = 0, wr_sel = 0;
    logic [7:0]  set_vector = '0;
    logic [31:0] wr_data = '0;
    logic        irq_pending, resp_valid, eoi_bcast;
    logic [1:0]  resp_kind;
    logic [7:0]  resp_vector, ppr, eoi_bcast_vector, task_prio;
    logic [12:0] spur_cfg;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0;
    logic [12:0]  m_cfg = 13'h0FF;

    always #2 clk = ~clk;

    irq_accept_core uut (.*);

    function automatic int hi(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic int m_ppr();
        int iv = hi(m_isr);
        int ic = (iv < 0) ? 0 : (iv >> 4);
        return ((m_tpr >> 4) >= ic) ? int'(m_tpr) : (ic << 4);
    endfunction

    function automatic bit m_pend();
        int rv = hi(m_irr);
        int p  = m_ppr();
        return m_cfg[8] && (rv >= 0) && ((p == 0) || ((rv >> 4) > (p >> 4)));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(irq_pending == m_pend(), {tag, " R3 pending"}, irq_pending, m_pend());
        chk(ppr == 8'(m_ppr()), {tag, " R2 ppr"}, ppr, m_ppr());
        chk(task_prio == m_tpr, {tag, " R10 tpr"}, task_prio, m_tpr);
        chk(spur_cfg == m_cfg, {tag, " R9 cfg"}, spur_cfg, m_cfg);
    endtask

    task automatic op_set(input int v, input bit lvl, input string tag);
        set_valid = 1; set_vector = 8'(v); set_level = lvl;
        @(negedge clk);
        set_valid = 0; set_level = 0;
        m_irr[v] = 1'b1; m_tmr[v] = lvl;
        check_state(tag);
    endtask

    task automatic op_wr(input bit sel, input logic [31:0] d, input string tag);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (sel) m_cfg = {d[12], 3'b000, d[8:0]};
        else     m_tpr = d[7:0];
        check_state(tag);
    endtask

    task automatic op_ack(input string tag);
        int ek, ev, rv;
        rv = hi(m_irr);
        if (!m_cfg[8] || rv < 0) begin ek = 0; ev = 0; end
        else if (m_pend()) begin ek = 1; ev = rv; m_irr[rv] = 1'b0; m_isr[rv] = 1'b1; end
        else begin ek = 2; ev = m_cfg[7:0]; end
        ack = 1;
        @(negedge clk);
        ack = 0;
        chk(resp_valid == 1'b1, {tag, " R12 resp_valid"}, resp_valid, 1);
        chk(resp_kind == 2'(ek), {tag, " kind"}, resp_kind, ek);
        if (ek != 0) chk(resp_vector == 8'(ev), {tag, " vector"}, resp_vector, ev);
        check_state(tag);
    endtask

    task automatic op_eoi(input string tag);
        int iv = hi(m_isr);
        bit eb = 0;
        if (iv >= 0) begin
            eb = m_tmr[iv] && !m_cfg[12];
            m_isr[iv] = 1'b0;
        end
        eoi = 1;
        @(negedge clk);
        eoi = 0;
        chk(eoi_bcast == eb, {tag, " bcast"}, eoi_bcast, eb);
        if (eb) chk(eoi_bcast_vector == 8'(iv), {tag, " bcast vector"}, eoi_bcast_vector, iv);
        check_state(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 R10: reset values
        check_state("R9 reset");
        chk(resp_valid == 0, "R12 no resp after reset", resp_valid, 0);

        // R8: disabled core keeps requests but offers nothing
        op_set(8'h50, 0, "R8 set while disabled");
        op_ack("R8 ack while disabled");
        @(negedge clk);
        chk(resp_valid == 0, "R12 resp only after ack", resp_valid, 1'b0);

        // R9: only bits 12 and 8:0 are stored
        op_wr(1, 32'hFFFF_F1AB, "R9 cfg mask");
        chk(spur_cfg == 13'h11AB, "R9 cfg value", spur_cfg, 13'h11AB);
        op_wr(1, 32'h0000_01F0, "R9 enable");
        op_ack("R8 kept request delivered");
        op_eoi("R6 edge retire");

        // R11: retirement with nothing in service
        op_eoi("R11 empty eoi");

        // R1 R5 R6: every vector, alternating trigger mode
        for (int v = 0; v < 256; v++) begin
            op_set(v, v[0], "R5 sweep set");
            op_ack("R1 sweep ack");
            op_eoi("R6 sweep eoi");
        end

        // R1 R4: nesting and a held request
        op_set(8'h23, 0, "R1 nest");
        op_set(8'h91, 1, "R1 nest");
        op_set(8'h47, 0, "R1 nest");
        op_ack("R1 highest first");
        op_ack("R4 spurious while 0x91 in service");
        op_eoi("R6 level retire 0x91");
        op_ack("R1 next 0x47");
        op_ack("R1 nested 0x23 blocked");
        op_eoi("R6 retire 0x47");
        op_ack("R1 0x23 after retire");
        op_eoi("R6 retire 0x23");

        // R2 R3 R4: task-priority class against request class
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                op_wr(0, 32'((t << 4) | 3), "R10 tpr write");
                op_set((c << 4) | 5, 0, "R3 class sweep");
                op_ack("R4 class sweep ack");
                if (hi(m_isr) < 0) begin
                    op_wr(0, 32'h0, "R10 tpr clear");
                    op_ack("R4 request kept");
                end
                op_eoi("R6 class sweep eoi");
            end
        end
        op_wr(0, 32'h0, "R10 tpr zero");

        // R5: later edge set overwrites level
        op_set(8'h66, 1, "R5 level");
        op_set(8'h66, 0, "R5 edge overwrite");
        op_ack("R1 0x66");
        op_eoi("R5 no bcast after overwrite");

        // R7: directed retirement suppresses broadcast
        op_wr(1, 32'h0000_11F0, "R7 directed on");
        op_set(8'h80, 1, "R7 level set");
        op_ack("R7 ack");
        op_eoi("R7 no bcast");

        // R8: disabling drops the pending line, request kept
        op_set(8'h70, 0, "R8 set");
        op_wr(1, 32'h0000_00F0, "R8 disable");
        op_ack("R8 none while disabled");
        op_wr(1, 32'h0000_01F0, "R8 re-enable");
        op_ack("R8 request survived");
        op_eoi("R6 final retire");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule